// File: doc/BRIEF.md
# Plug-and-Play Initiation Key Detector

This block sits on the host write path of a plug-and-play card and decides when the card may leave its wait-for-key state. It watches byte writes to one fixed port address. Before the key, the host sends a preamble of two zero bytes. The host then sends a 32-byte key, one byte per write. The block does not store the key. It rebuilds each expected byte with an 8-bit linear-feedback shift register and compares every incoming byte with the current register value as the write arrives.

When all 32 bytes match, the block raises a sticky `unlocked` flag, which gates the card's configuration register logic. A wrong byte sends the detector back to hunting for the zero preamble. The flag is cleared only by reset or by a dedicated return-to-wait request.

Top module: `pnp_key_detect`

## Requirements
- R1: After reset `unlocked` is 0 and the detector waits for the zero preamble.
- R2: The key is 32 bytes long and starts from 0x6A. Each following byte is {b0 XOR b1, b[7:1]} of the previous one, so the key begins 0x6A, 0xB5, 0xDA, 0xED and ends 0x73, 0x39.
- R3: Key bytes are accepted only after two consecutive 0x00 writes. A non-zero write between the two zeros restarts the preamble hunt, and a key sent with no preamble never unlocks.
- R4: A non-zero byte that differs from the expected key byte returns the detector to the preamble hunt, and the rest of that key attempt cannot unlock.
- R5: A write counts only when `wr_en` is 1 and `wr_addr` equals KEY_ADDR (default 0x279). Other bus activity leaves the detector state and `unlocked` unchanged.
- R6: `unlocked` rises on the clock edge that takes the 32nd matching byte, and not on any earlier edge.
- R7: Once set, `unlocked` stays 1 whatever bytes are written afterwards.
- R8: `wait_cmd` clears `unlocked` and returns the detector to the preamble hunt on the next edge. It wins over a key write in the same cycle.
- R9: A 0x00 write in place of the first key byte is taken as an extra preamble byte. A 0x00 write later in the key counts as the first zero of a new preamble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host byte-write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write data byte |
| wait_cmd | input | 1 | Return-to-wait request; clears the unlock |
| unlocked | output | 1 | Sticky flag: the full key has been seen |

## Verification
Most internal faults show up only at the end of a key attempt. A wrong sequencer state, a slipped byte index or a bad shift-register step would unlock one edge early, one edge late, or never, so the bench samples `unlocked` both after byte 31 and after byte 32. A detector that fails to resynchronise shows up one attempt later, when a correct key that follows a corrupted one or a zero inside the key does not unlock. Leakage from foreign addresses or a weak sticky bit shows on the first write after the event.

// File: rtl/pnp_key_pkg.sv
package pnp_key_pkg;

    // Detector phases: hunt for first zero, hunt for second zero,
    // matching key bytes, key accepted.
    typedef enum logic [1:0] {
        ST_HUNT0 = 2'd0,
        ST_HUNT1 = 2'd1,
        ST_MATCH = 2'd2,
        ST_OPEN  = 2'd3
    } key_state_e;

endpackage

// File: rtl/pnp_key_port_match.sv
module pnp_key_port_match #(
    parameter int unsigned          ADDR_W   = 12,
    parameter logic [ADDR_W-1:0]    KEY_ADDR = 12'h279
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              hit
);
    always_comb begin
        hit = wr_en && (wr_addr == KEY_ADDR);
    end
endmodule

// File: rtl/pnp_key_lfsr_step.sv
module pnp_key_lfsr_step #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    // Feedback from the two low bits enters at the top; the rest shifts down.
    always_comb begin
        nxt = {cur[0] ^ cur[1], cur[W-1:1]};
    end
endmodule

// File: rtl/pnp_key_seq.sv
module pnp_key_seq
    import pnp_key_pkg::*;
#(
    parameter int unsigned   W       = 8,
    parameter int unsigned   KEY_LEN = 32,
    parameter logic [W-1:0]  SEED    = 8'h6A
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit,
    input  logic [W-1:0] data,
    input  logic         wait_cmd,
    output logic         unlocked
);
    localparam int unsigned     CNT_W    = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(KEY_LEN - 1);

    typedef struct packed {
        key_state_e      state;
        logic [CNT_W-1:0] idx;
        logic [W-1:0]     expect_b;
        logic             unlocked;
    } seq_t;

    seq_t         s_d, s_q;
    logic [W-1:0] step_w;
    logic         is_zero;
    logic         is_match;

    pnp_key_lfsr_step #(.W(W)) u_step (
        .cur (s_q.expect_b),
        .nxt (step_w)
    );

    always_comb begin
        is_zero  = (data == '0);
        is_match = (data == s_q.expect_b);
        s_d      = s_q;
        if (wait_cmd) begin
            s_d.state    = ST_HUNT0;
            s_d.idx      = '0;
            s_d.expect_b = SEED;
            s_d.unlocked = 1'b0;
        end else if (hit) begin
            unique case (s_q.state)
                ST_HUNT0: begin
                    if (is_zero) s_d.state = ST_HUNT1;
                end
                ST_HUNT1: begin
                    if (is_zero) begin
                        s_d.state    = ST_MATCH;
                        s_d.idx      = '0;
                        s_d.expect_b = SEED;
                    end else begin
                        s_d.state = ST_HUNT0;
                    end
                end
                ST_MATCH: begin
                    if (is_match) begin
                        if (s_q.idx == LAST_IDX) begin
                            s_d.state    = ST_OPEN;
                            s_d.unlocked = 1'b1;
                        end else begin
                            s_d.idx      = s_q.idx + CNT_W'(1);
                            s_d.expect_b = step_w;
                        end
                    end else if (is_zero) begin
                        // Extra preamble zero before the key keeps position;
                        // a zero inside the key starts a new preamble.
                        if (s_q.idx != '0) s_d.state = ST_HUNT1;
                    end else begin
                        s_d.state = ST_HUNT0;
                    end
                end
                ST_OPEN: begin
                    s_d = s_q;
                end
                default: s_d.state = ST_HUNT0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state    <= ST_HUNT0;
            s_q.idx      <= '0;
            s_q.expect_b <= SEED;
            s_q.unlocked <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign unlocked = s_q.unlocked;
endmodule

// File: rtl/pnp_key_detect.sv
module pnp_key_detect #(
    parameter int unsigned        ADDR_W   = 12,
    parameter logic [ADDR_W-1:0]  KEY_ADDR = 12'h279,
    parameter int unsigned        KEY_LEN  = 32,
    parameter logic [7:0]         SEED     = 8'h6A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              wait_cmd,
    output logic              unlocked
);
    logic hit;

    pnp_key_port_match #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR)) u_match (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .hit     (hit)
    );

    pnp_key_seq #(.W(8), .KEY_LEN(KEY_LEN), .SEED(SEED)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .data     (wr_data),
        .wait_cmd (wait_cmd),
        .unlocked (unlocked)
    );
endmodule

// File: rtl/pnp_key_detect_chk.sv
module pnp_key_detect_chk #(
    parameter int unsigned        ADDR_W   = 12,
    parameter logic [ADDR_W-1:0]  KEY_ADDR = 12'h279,
    parameter int unsigned        KEY_LEN  = 32,
    parameter logic [7:0]         SEED     = 8'h6A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              wait_cmd,
    input logic              unlocked
);
    function automatic logic [7:0] final_byte();
        logic [7:0] b;
        b = SEED;
        for (int i = 1; i < KEY_LEN; i++) b = {b[0] ^ b[1], b[7:1]};
        return b;
    endfunction

    localparam logic [7:0] LAST_BYTE = final_byte();

    logic port_hit;
    assign port_hit = wr_en && (wr_addr == KEY_ADDR);

    // R6: a rise needs a key-port write of the final key byte on the edge before
    assert_rise_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> ($past(port_hit) && !$past(wait_cmd) && ($past(wr_data) == LAST_BYTE)));

    // R7: sticky unless a return-to-wait request arrives
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && !wait_cmd) |=> unlocked);

    // R8: return-to-wait clears the flag on the next edge
    assert_wait_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cmd |=> !unlocked);

    // R5: no key-port write and no request leaves the flag unchanged
    assert_foreign_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_hit && !wait_cmd) |=> $stable(unlocked));

    // R1: flag is low while reset is held
    always @(posedge clk) begin
        if (!rst_n) assert_reset_low_R1: assert (!unlocked);
    end
endmodule

bind pnp_key_detect pnp_key_detect_chk #(
    .ADDR_W   (ADDR_W),
    .KEY_ADDR (KEY_ADDR),
    .KEY_LEN  (KEY_LEN),
    .SEED     (SEED)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wait_cmd (wait_cmd),
    .unlocked (unlocked)
);

// File: tb/pnp_key_detect_bench.sv
module pnp_key_detect_bench;
    localparam logic [11:0] KADDR = 12'h279;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wait_cmd = 1'b0;
    logic        unlocked;

    int total = 0;
    int bad = 0;
    logic [7:0] key [32];

    always #2 clk = ~clk;

    pnp_key_detect u_pnp_key_detect (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wait_cmd(wait_cmd), .unlocked(unlocked)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_wait();
        @(negedge clk); wait_cmd = 1'b1;
        @(negedge clk); wait_cmd = 1'b0;
    endtask

    // Sends bytes key[0..upto-1]; byte bad_i gets bit 0 flipped (-1 for none).
    task automatic send_key(input int upto, input int bad_i);
        for (int i = 0; i < upto; i++)
            wr(KADDR, (i == bad_i) ? (key[i] ^ 8'h01) : key[i]);
    endtask

    task automatic t_sequence();
        check(key[0], 8'h6A, "R2 key[0]");
        check(key[1], 8'hB5, "R2 key[1]");
        check(key[2], 8'hDA, "R2 key[2]");
        check(key[3], 8'hED, "R2 key[3]");
        check(key[30], 8'h73, "R2 key[30]");
        check(key[31], 8'h39, "R2 key[31]");
    endtask

    task automatic t_full_unlock();
        wr(KADDR, 8'h00); wr(KADDR, 8'h00);
        send_key(31, -1);
        check(unlocked, 1'b0, "R6 not after 31 bytes");
        wr(KADDR, key[31]);
        check(unlocked, 1'b1, "R6 set after 32 bytes");
        wr(KADDR, 8'h00); wr(KADDR, 8'h55); wr(KADDR, key[0]);
        check(unlocked, 1'b1, "R7 sticky after writes");
        do_wait();
        check(unlocked, 1'b0, "R8 wait clears");
    endtask

    task automatic t_corrupt();
        wr(KADDR, 8'h00); wr(KADDR, 8'h00);
        send_key(32, 15);
        check(unlocked, 1'b0, "R4 corrupted byte 15");
        wr(KADDR, 8'h00); wr(KADDR, 8'h00);
        send_key(32, -1);
        check(unlocked, 1'b1, "R4 recovers after preamble");
        do_wait();
    endtask

    task automatic t_no_preamble();
        send_key(32, -1);
        check(unlocked, 1'b0, "R3 key without preamble");
        wr(KADDR, 8'h00); wr(KADDR, 8'h12); wr(KADDR, 8'h00);
        send_key(32, -1);
        check(unlocked, 1'b0, "R3 broken preamble");
        do_wait();
    endtask

    task automatic t_foreign();
        wr(KADDR, 8'h00); wr(KADDR, 8'h00);
        for (int i = 0; i < 32; i++) begin
            wr(12'h278, 8'hA5);
            @(negedge clk); wr_en = 1'b0; wr_addr = KADDR; wr_data = 8'h33;
            wr(KADDR, key[i]);
        end
        check(unlocked, 1'b1, "R5 foreign writes ignored");
        do_wait();
    endtask

    task automatic t_zeros();
        wr(KADDR, 8'h00); wr(KADDR, 8'h00); wr(KADDR, 8'h00);
        send_key(32, -1);
        check(unlocked, 1'b1, "R9 extra leading zero");
        do_wait();
        wr(KADDR, 8'h00); wr(KADDR, 8'h00);
        send_key(5, -1);
        wr(KADDR, 8'h00); wr(KADDR, 8'h00);
        send_key(32, -1);
        check(unlocked, 1'b1, "R9 zero mid-key restarts");
        do_wait();
    endtask

    task automatic t_wait_priority();
        wr(KADDR, 8'h00); wr(KADDR, 8'h00);
        send_key(31, -1);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = KADDR; wr_data = key[31]; wait_cmd = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wait_cmd = 1'b0;
        check(unlocked, 1'b0, "R8 wait beats last byte");
    endtask

    task automatic t_reset_mid();
        wr(KADDR, 8'h00); wr(KADDR, 8'h00);
        send_key(32, -1);
        check(unlocked, 1'b1, "R6 unlock before reset");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(unlocked, 1'b0, "R1 reset clears");
        send_key(32, -1);
        check(unlocked, 1'b0, "R1 waits for preamble");
    endtask

    initial begin
        key[0] = 8'h6A;
        for (int i = 1; i < 32; i++) key[i] = {key[i-1][0] ^ key[i-1][1], key[i-1][7:1]};
        repeat (3) @(negedge clk);
        check(unlocked, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(unlocked, 1'b0, "R1 after reset");
        t_sequence();
        t_full_unlock();
        t_corrupt();
        t_no_preamble();
        t_foreign();
        t_zeros();
        t_wait_priority();
        t_reset_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule